// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between six interrupt sources and a processor core. Each source gives a one-cycle event pulse, which is held in a pending latch until the source is served. Every source has a 3-bit priority value. The controller also holds a per-source enable, a global enable, and a separate user suspend switch. It picks the best pending request that is allowed to run. That request interrupts the running code only when its priority value is strictly below the level the core is running at. Lower values are more urgent, and level 0 is the most urgent.

The sources are numbered as follows: 0 is converter-done, 1 to 3 are the three timers, 4 is the serial port and 5 is the external pin. When a request is taken, the block does four things in one step. It gives a one-cycle strobe with the 3-bit source index, clears that pending latch, saves the interrupted level on an internal stack, and raises the running level to the level of the request. A return command pops the stack. The core uses the running-level output to pick its condition-flag bank. The main program runs at the least urgent level, 6.

The priority configuration comes in on a flat port. It is all zeros until software writes it, so software should program the priorities before it turns on the global enable.

Top module: `irq_nest_ctrl`

## Requirements
- R1: An event pulse on any of the six sources sets a pending latch that stays set while the source is masked, disabled or outranked, and is cleared only when that source is taken.
- R2: After reset the running level output is 6 (main program), the strobe is low and the global enable is off.
- R3: A pending, allowed request whose priority value is lower than the running level is taken on the clock edge after its latch is set. In the cycle after that edge, `irq_stb` is high for one cycle, `irq_vec` holds the source index and `cur_lvl` equals its priority value.
- R4: A pending request whose priority value is equal to or greater than the running level is not taken until returns bring the running level above its value.
- R5: Among allowed pending requests, the lowest priority value wins. When two requests have the same value, the one with the lower source index wins.
- R6: A source whose bit in `src_en` is 0 is never taken. Its pending latch remains set, and it is taken once the bit is set to 1.
- R7: `gie_set` turns the global enable on and `gie_clr` turns it off, with clear winning if both are high. No request is taken while the global enable is off.
- R8: `usr_dis` suspends all taking and `usr_ena` resumes it. Neither touches the global enable or `src_en`. Resume wins if both are high.
- R9: Each take saves the interrupted level. Each `reti` pulse restores the most recently saved level on the next edge. Nesting works through all seven levels, from main down to level 0.
- R10: A `reti` at the main level is ignored, and the level stays 6. A `reti` in the same cycle as an eligible request blocks the take for that cycle.
- R11: A source with priority value 6 or 7 is never taken, because no running level is ever above 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_evt | input | 6 | One-cycle event pulses, one bit per source |
| src_en | input | 6 | Per-source enable, 1 = allowed |
| prio_cfg | input | 18 | Priority value of source i in bits [3i+2:3i] |
| gie_set | input | 1 | Pulse: turn the global enable on |
| gie_clr | input | 1 | Pulse: turn the global enable off |
| usr_dis | input | 1 | Pulse: suspend taking without changing masks |
| usr_ena | input | 1 | Pulse: resume taking |
| reti | input | 1 | Pulse: return from the current routine |
| irq_stb | output | 1 | One-cycle strobe marking a taken request |
| irq_vec | output | 3 | Index of the taken source, valid with `irq_stb` |
| cur_lvl | output | 3 | Running level, used by the core to select its flag bank |

## Verification
The checker enforces several rules on every cycle:
- The running level only ever moves strictly more urgent when a take happens.
- The running level holds unless there is a take or a return.
- A take happens only if the gates were open in the cycle before.
- The stack is empty exactly when the level is 6.
- A return on a non-empty stack removes exactly one entry.

The bench scenarios cover what the checker cannot see: which source wins a tie, that pending latches survive masking and suspension, the full seven-level unwind order, and the collision between a return and an eligible request.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int unsigned DEF_NSRC = 6;
  localparam int unsigned DEF_NLVL = 7;

  // request priority value beats the running level only when strictly smaller
  function automatic bit outranks(int unsigned req_lvl, int unsigned run_lvl);
    return req_lvl < run_lvl;
  endfunction

  // candidate a replaces best b when more urgent, or equal and scanned from lower index
  function automatic bit better_or_tie(int unsigned a_lvl, int unsigned b_lvl);
    return a_lvl <= b_lvl;
  endfunction
endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int unsigned NSRC = 6,
  parameter int unsigned SRCW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic            clr_en,
  input  logic [SRCW-1:0] clr_idx,
  output logic [NSRC-1:0] pend
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic clr_this;
    assign clr_this = clr_en && (clr_idx == SRCW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend[i] <= 1'b0;
      else if (evt[i])   pend[i] <= 1'b1;  // a fresh event outlives a same-edge clear
      else if (clr_this) pend[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_nest_pkg::*;
#(
  parameter int unsigned NSRC = 6,
  parameter int unsigned LVLW = 3,
  parameter int unsigned SRCW = 3
) (
  input  logic [NSRC-1:0]      cand,
  input  logic [NSRC*LVLW-1:0] prio_flat,
  input  logic [LVLW-1:0]      run_lvl,
  output logic                 hit,
  output logic [SRCW-1:0]      win_idx,
  output logic [LVLW-1:0]      win_lvl
);
  logic            any;
  logic [LVLW-1:0] best;
  logic [SRCW-1:0] best_idx;

  always_comb begin
    any      = 1'b0;
    best     = '1;
    best_idx = '0;
    // scan from the top index down so that ties settle on the lowest index
    for (int i = int'(NSRC) - 1; i >= 0; i--) begin
      if (cand[i] && (!any || better_or_tie(int'(prio_flat[i*LVLW +: LVLW]), int'(best)))) begin
        any      = 1'b1;
        best     = prio_flat[i*LVLW +: LVLW];
        best_idx = SRCW'(i);
      end
    end
    hit     = any && outranks(int'(best), int'(run_lvl));
    win_idx = best_idx;
    win_lvl = best;
  end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack #(
  parameter int unsigned NLVL = 7,
  parameter int unsigned LVLW = 3,
  parameter int unsigned DPW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [LVLW-1:0] push_lvl,
  input  logic            pop,
  output logic [LVLW-1:0] cur_lvl,
  output logic [DPW-1:0]  depth
);
  localparam logic [LVLW-1:0] MAIN = LVLW'(NLVL - 1);

  logic [LVLW-1:0] saved [NLVL];
  logic            do_pop;
  logic            do_push;

  assign do_pop  = pop && (depth != '0);
  assign do_push = push && !pop && (depth != DPW'(NLVL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_lvl <= MAIN;
      depth   <= '0;
    end else if (do_pop) begin
      cur_lvl <= saved[depth - DPW'(1)];
      depth   <= depth - DPW'(1);
    end else if (do_push) begin
      cur_lvl <= push_lvl;
      depth   <= depth + DPW'(1);
    end
  end

  for (genvar k = 0; k < NLVL; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             saved[k] <= MAIN;
      else if (do_push && depth == DPW'(k))   saved[k] <= cur_lvl;
    end
  end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int unsigned NSRC = DEF_NSRC,
  parameter int unsigned NLVL = DEF_NLVL,
  localparam int unsigned LVLW = $clog2(NLVL),
  localparam int unsigned SRCW = $clog2(NSRC),
  localparam int unsigned DPW  = $clog2(NLVL + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      src_evt,
  input  logic [NSRC-1:0]      src_en,
  input  logic [NSRC*LVLW-1:0] prio_cfg,
  input  logic                 gie_set,
  input  logic                 gie_clr,
  input  logic                 usr_dis,
  input  logic                 usr_ena,
  input  logic                 reti,
  output logic                 irq_stb,
  output logic [SRCW-1:0]      irq_vec,
  output logic [LVLW-1:0]      cur_lvl
);
  logic            gie_q;
  logic            susp_q;
  logic            glb_on;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] cand;
  logic            arb_hit;
  logic [SRCW-1:0] win_idx;
  logic [LVLW-1:0] win_lvl;
  logic            take;
  logic [DPW-1:0]  stk_depth;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      susp_q <= 1'b0;
    end else begin
      if (gie_clr)      gie_q <= 1'b0;
      else if (gie_set) gie_q <= 1'b1;
      if (usr_ena)      susp_q <= 1'b0;
      else if (usr_dis) susp_q <= 1'b1;
    end
  end

  assign glb_on = gie_q && !susp_q;
  assign cand   = pend & src_en & {NSRC{glb_on}};
  assign take   = arb_hit && !reti;

  irq_pend_latch #(.NSRC(NSRC), .SRCW(SRCW)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt(src_evt),
    .clr_en(take), .clr_idx(win_idx), .pend(pend)
  );

  irq_prio_arb #(.NSRC(NSRC), .LVLW(LVLW), .SRCW(SRCW)) u_arb (
    .cand(cand), .prio_flat(prio_cfg), .run_lvl(cur_lvl),
    .hit(arb_hit), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  irq_lvl_stack #(.NLVL(NLVL), .LVLW(LVLW), .DPW(DPW)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(take), .push_lvl(win_lvl),
    .pop(reti), .cur_lvl(cur_lvl), .depth(stk_depth)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_stb <= 1'b0;
      irq_vec <= '0;
    end else begin
      irq_stb <= take;
      if (take) irq_vec <= win_idx;
    end
  end
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
  parameter int unsigned NSRC = 6,
  parameter int unsigned NLVL = 7,
  parameter int unsigned LVLW = 3,
  parameter int unsigned SRCW = 3,
  parameter int unsigned DPW  = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_stb,
  input logic [SRCW-1:0] irq_vec,
  input logic [LVLW-1:0] cur_lvl,
  input logic            reti,
  input logic            glb_on,
  input logic [DPW-1:0]  depth
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R3
  raise_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && irq_stb) |-> (cur_lvl < $past(cur_lvl)));

  // R3
  vec_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stb |-> (int'(irq_vec) < int'(NSRC)));

  // R11
  lvl_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cur_lvl) <= int'(NLVL) - 1);

  // R7
  gated_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && irq_stb) |-> $past(glb_on));

  // R4
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !irq_stb && !$past(reti)) |-> (cur_lvl == $past(cur_lvl)));

  // R10
  empty_is_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (depth == '0) == (int'(cur_lvl) == int'(NLVL) - 1));

  // R9
  pop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(reti) && $past(depth) != '0) |-> (depth == $past(depth) - DPW'(1)));
endmodule

bind irq_nest_ctrl irq_nest_chk #(
  .NSRC(NSRC), .NLVL(NLVL), .LVLW(LVLW), .SRCW(SRCW), .DPW(DPW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_stb(irq_stb), .irq_vec(irq_vec),
  .cur_lvl(cur_lvl), .reti(reti), .glb_on(glb_on), .depth(stk_depth)
);

// File: tb/irq_nest_ctrl_test.sv
`timescale 1ns/1ps
module irq_nest_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  src_evt = '0;
  logic [5:0]  src_en = '0;
  logic [17:0] prio_cfg = '0;
  logic        gie_set = 1'b0, gie_clr = 1'b0, usr_dis = 1'b0, usr_ena = 1'b0, reti = 1'b0;
  logic        irq_stb;
  logic [2:0]  irq_vec;
  logic [2:0]  cur_lvl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_nest_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .src_en(src_en), .prio_cfg(prio_cfg),
    .gie_set(gie_set), .gie_clr(gie_clr), .usr_dis(usr_dis), .usr_ena(usr_ena),
    .reti(reti), .irq_stb(irq_stb), .irq_vec(irq_vec), .cur_lvl(cur_lvl)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_prio(input int src, input int lvl);
    prio_cfg[src*3 +: 3] = 3'(lvl);
  endtask

  task automatic pulse_evt(input logic [5:0] m);
    @(negedge clk) src_evt = m;
    @(negedge clk) src_evt = '0;
  endtask

  task automatic expect_take(input int vec, input int lvl, input string tag);
    @(negedge clk);
    chk(irq_stb == 1'b1, {tag, " strobe"}, int'(irq_stb), 1);
    chk(int'(irq_vec) == vec, {tag, " vector"}, int'(irq_vec), vec);
    chk(int'(cur_lvl) == lvl, {tag, " level"}, int'(cur_lvl), lvl);
  endtask

  task automatic expect_none(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(irq_stb == 1'b0, {tag, " no strobe"}, int'(irq_stb), 0);
    end
  endtask

  task automatic do_reti(input int exp_lvl, input string tag);
    @(negedge clk) reti = 1'b1;
    @(negedge clk) reti = 1'b0;
    chk(int'(cur_lvl) == exp_lvl, {tag, " return level"}, int'(cur_lvl), exp_lvl);
  endtask

  task automatic t_reset;
    chk(int'(cur_lvl) == 6, "R2 reset level", int'(cur_lvl), 6);
    chk(irq_stb == 1'b0, "R2 reset strobe", int'(irq_stb), 0);
  endtask

  task automatic t_global;
    src_en = '1;
    set_prio(3, 2);
    pulse_evt(6'b001000);
    expect_none(3, "R7 global off");
    @(negedge clk) gie_set = 1'b1;
    @(negedge clk) gie_set = 1'b0;
    expect_take(3, 2, "R1 R7 latched then enabled");
    do_reti(6, "R9 single");
  endtask

  task automatic t_wait;
    set_prio(1, 2);
    set_prio(0, 4);
    pulse_evt(6'b001000);
    expect_take(3, 2, "R3 preempt main");
    pulse_evt(6'b000010);
    expect_none(2, "R4 equal level waits");
    pulse_evt(6'b000001);
    expect_none(2, "R4 lower level waits");
    do_reti(6, "R4 back to main");
    expect_take(1, 2, "R4 R5 waiting more urgent first");
    do_reti(6, "R4 second return");
    expect_take(0, 4, "R4 remaining request");
    do_reti(6, "R4 third return");
  endtask

  task automatic t_tie;
    set_prio(2, 3);
    set_prio(4, 3);
    pulse_evt(6'b010100);
    expect_take(2, 3, "R5 tie lower index");
    do_reti(6, "R5 return");
    expect_take(4, 3, "R5 tie other source");
    do_reti(6, "R5 return two");
  endtask

  task automatic t_mask;
    set_prio(5, 1);
    src_en[5] = 1'b0;
    pulse_evt(6'b100000);
    expect_none(3, "R6 masked");
    @(negedge clk) src_en[5] = 1'b1;
    expect_take(5, 1, "R6 unmasked pending");
    do_reti(6, "R6 return");
  endtask

  task automatic t_suspend;
    set_prio(0, 4);
    @(negedge clk) usr_dis = 1'b1;
    @(negedge clk) usr_dis = 1'b0;
    pulse_evt(6'b000001);
    expect_none(3, "R8 suspended");
    @(negedge clk) usr_ena = 1'b1;
    @(negedge clk) usr_ena = 1'b0;
    expect_take(0, 4, "R8 resumed with masks kept");
    do_reti(6, "R8 return");
  endtask

  task automatic t_low;
    set_prio(1, 6);
    set_prio(2, 7);
    pulse_evt(6'b000110);
    expect_none(4, "R11 levels 6 and 7");
    set_prio(1, 0);
    expect_take(1, 0, "R1 R11 still pending after reprogram");
    set_prio(2, 5);
    do_reti(6, "R11 return");
    expect_take(2, 5, "R1 second retained request");
    do_reti(6, "R11 return two");
  endtask

  task automatic t_nest;
    for (int s = 0; s < 6; s++) set_prio(s, 5 - s);
    for (int s = 0; s < 6; s++) begin
      pulse_evt(6'(1 << s));
      expect_take(s, 5 - s, "R9 nest in");
    end
    for (int d = 1; d <= 6; d++) do_reti(d, "R9 nest out");
  endtask

  task automatic t_ret_edge;
    do_reti(6, "R10 return at main");
    expect_none(2, "R10 idle after stray return");
    set_prio(3, 2);
    set_prio(4, 1);
    pulse_evt(6'b001000);
    expect_take(3, 2, "R10 setup");
    pulse_evt(6'b010000);
    // pending and eligible now; return lands on the same edge as the would-be take
    reti = 1'b1;
    @(negedge clk) reti = 1'b0;
    chk(irq_stb == 1'b0, "R10 return blocks take", int'(irq_stb), 0);
    chk(int'(cur_lvl) == 6, "R10 popped level", int'(cur_lvl), 6);
    expect_take(4, 1, "R10 take after return");
    do_reti(6, "R10 final return");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_global;
    t_wait;
    t_tie;
    t_mask;
    t_suspend;
    t_low;
    t_nest;
    t_ret_edge;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule